// File: doc/BRIEF.md
# Serial Interrupt Priority Arbiter

This block decides which of several interrupt sources that share one priority level is served when the processor acknowledges an interrupt. Every source owns a 4-bit arbitration number, held in a small register bank inside the block. Slot 0 belongs to the system integration source. Any request from outside the chip is merged into that slot, so slot 0's number also decides external requests against internal ones.

An acknowledge strobe starts a contention round. The block first takes a snapshot of the pending requests and of their arbitration numbers. It then walks the bits from the most significant down, one bit per clock. Each remaining contender drives its current bit onto a shared wired-OR line. A contender that drives 0 while the line reads 1 drops out for the rest of the round.

After the last bit, the block pulses a done strobe and reports one of two outcomes. The first is the index of the surviving source. The second is a spurious-interrupt flag, raised when nobody answered or when the survivor's number is zero. An error flag marks two sources that tie on the same non-zero number.

Top module: `serial_irq_arbiter`

## Requirements
- R1: After reset, slot 0's arbitration number is 4'b1111 and every other slot's number is 4'b0000.
- R2: When `fld_load[i]` is high at a rising edge, `fld_value` is written into slot i's arbitration number.
- R3: An `ack` that is high at a rising edge while no round is running starts a round. `done` is high for exactly one cycle, the cycle after the fourth rising edge that follows the starting edge.
- R4: The winner is the requesting slot with the numerically largest arbitration number. Among equal largest numbers, the lowest index wins. This outcome comes from an MSB-first, bit-serial wired-OR contention.
- R5: A round runs for the full four bit steps and reports through `done`, even when only one request, or no request, is pending.
- R6: `spurious` is reported when no slot was requesting, or when the winning number is 4'b0000. In that case `winner_idx` reads 0.
- R7: `dup_err` is reported when two or more requesting slots share the winning non-zero number. `dup_err` is never high together with `spurious`.
- R8: `ext_irq` acts as a request on slot 0 and uses slot 0's arbitration number.
- R9: A round uses the requests and numbers captured at its starting edge. Changes to `irq_req`, `ext_irq` and `ack` during a round have no effect on its outcome. Field loads during a round also have no effect on its outcome.
- R10: `winner_idx`, `spurious` and `dup_err` change only when `done` rises, and hold their values between rounds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | N | Request flag per source slot |
| ext_irq | input | 1 | External request, merged into slot 0 |
| fld_load | input | N | Per-slot write enable for the arbitration number |
| fld_value | input | W | Arbitration number to write |
| ack | input | 1 | Interrupt acknowledge strobe, starts a round |
| winner_idx | output | $clog2(N) | Index of the winning slot |
| done | output | 1 | One-cycle pulse at the end of a round |
| spurious | output | 1 | No valid winner in the last round |
| dup_err | output | 1 | Two requesters tied on the winning non-zero number |

## Verification
The bench targets several corner cases, each paired with the failure it would expose:
- Ties on the winning number. A design that resolved bits in the wrong order, or broke ties toward the higher index, would name the wrong winner or miss the error flag.
- Rounds with a lone requester, with no requester, and with all-zero numbers. A design that skipped contention would break the fixed latency. A design that ignored zero numbers would report a winner where a spurious indication is due.
- Traffic during a round. The bench flips requests, repeats the acknowledge and rewrites numbers while a round runs. A design without a snapshot would let that traffic change the outcome or restart the round.
- The reset values of the numbers and the merging of the external request. These are checked before any number is written.

// File: rtl/sia_pkg.sv
package sia_pkg;

  // Width of an index able to address n slots (at least one bit).
  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Reset value of a slot's arbitration number: the system slot starts
  // at all ones, all other slots at zero.
  function automatic int unsigned reset_number(input int unsigned slot, input int unsigned w);
    return (slot == 0) ? ((1 << w) - 1) : 0;
  endfunction

endpackage

// File: rtl/sia_field_bank.sv
module sia_field_bank #(
  parameter int unsigned N = 8,
  parameter int unsigned W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N-1:0]          fld_load,
  input  logic [W-1:0]          fld_value,
  output logic [N-1:0][W-1:0]   numbers
);
  import sia_pkg::*;

  for (genvar s = 0; s < N; s++) begin : g_slot
    localparam logic [W-1:0] RST_VAL = W'(reset_number(s, W));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           numbers[s] <= RST_VAL;
      else if (fld_load[s]) numbers[s] <= fld_value;
    end
  end

endmodule

// File: rtl/sia_contend_lane.sv
module sia_contend_lane #(
  parameter int unsigned W  = 4,
  parameter int unsigned BW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          step,
  input  logic          req_in,
  input  logic [W-1:0]  number_in,
  input  logic [BW-1:0] bit_pos,
  input  logic          line_level,
  output logic          drive,
  output logic          stays,
  output logic          active,
  output logic [W-1:0]  number_q
);

  logic cur_bit;

  assign cur_bit = number_q[bit_pos];
  assign drive   = active & cur_bit;
  // A contender that offers 0 against a 1 on the line drops out.
  assign stays   = active & ~(line_level & ~cur_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      number_q <= '0;
    end else if (start) begin
      active   <= req_in;
      number_q <= number_in;
    end else if (step) begin
      active   <= stays;
    end
  end

endmodule

// File: rtl/sia_resolve.sv
module sia_resolve #(
  parameter int unsigned N     = 8,
  parameter int unsigned W     = 4,
  parameter int unsigned IDX_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                last_step,
  input  logic [N-1:0]        survivors,
  input  logic [N-1:0][W-1:0] numbers_q,
  output logic [IDX_W-1:0]    winner_idx,
  output logic                done,
  output logic                spurious,
  output logic                dup_err
);

  function automatic logic [IDX_W-1:0] lowest_set(input logic [N-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  logic [IDX_W-1:0] pick;
  logic [W-1:0]     pick_num;
  logic             no_winner;
  logic             tie;

  assign pick      = lowest_set(survivors);
  assign pick_num  = numbers_q[pick];
  assign no_winner = (survivors == '0) || (pick_num == '0);
  assign tie       = ($countones(survivors) > 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      winner_idx <= '0;
      done       <= 1'b0;
      spurious   <= 1'b0;
      dup_err    <= 1'b0;
    end else begin
      done <= last_step;
      if (last_step) begin
        winner_idx <= no_winner ? '0 : pick;
        spurious   <= no_winner;
        dup_err    <= ~no_winner & tie;
      end
    end
  end

endmodule

// File: rtl/serial_irq_arbiter.sv
module serial_irq_arbiter #(
  parameter int unsigned N     = 8,
  parameter int unsigned W     = 4,
  parameter int unsigned IDX_W = sia_pkg::idx_width(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     irq_req,
  input  logic             ext_irq,
  input  logic [N-1:0]     fld_load,
  input  logic [W-1:0]     fld_value,
  input  logic             ack,
  output logic [IDX_W-1:0] winner_idx,
  output logic             done,
  output logic             spurious,
  output logic             dup_err
);
  import sia_pkg::*;

  localparam int unsigned BW = idx_width(W);
  localparam logic [BW-1:0] TOP_BIT = BW'(W - 1);

  // Named internal events, observed by the bound checker.
  logic                round_active;
  logic [BW-1:0]       bit_pos;
  logic                start;
  logic                step;
  logic                last_step;
  logic                line_level;
  logic [N-1:0]        contenders;
  logic [N-1:0]        survivors;
  logic [N-1:0]        drives;
  logic [N-1:0]        req_eff;
  logic [N-1:0][W-1:0] numbers;
  logic [N-1:0][W-1:0] numbers_q;

  assign req_eff    = irq_req | {{(N-1){1'b0}}, ext_irq};
  assign start      = ack & ~round_active;
  assign step       = round_active;
  assign last_step  = round_active & (bit_pos == '0);
  assign line_level = |drives;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      round_active <= 1'b0;
      bit_pos      <= '0;
    end else if (start) begin
      round_active <= 1'b1;
      bit_pos      <= TOP_BIT;
    end else if (step) begin
      if (bit_pos == '0) round_active <= 1'b0;
      else               bit_pos      <= bit_pos - 1'b1;
    end
  end

  sia_field_bank #(.N(N), .W(W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .fld_load  (fld_load),
    .fld_value (fld_value),
    .numbers   (numbers)
  );

  for (genvar s = 0; s < N; s++) begin : g_lane
    sia_contend_lane #(.W(W), .BW(BW)) u_lane (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .step       (step),
      .req_in     (req_eff[s]),
      .number_in  (numbers[s]),
      .bit_pos    (bit_pos),
      .line_level (line_level),
      .drive      (drives[s]),
      .stays      (survivors[s]),
      .active     (contenders[s]),
      .number_q   (numbers_q[s])
    );
  end

  sia_resolve #(.N(N), .W(W), .IDX_W(IDX_W)) u_resolve (
    .clk        (clk),
    .rst_n      (rst_n),
    .last_step  (last_step),
    .survivors  (survivors),
    .numbers_q  (numbers_q),
    .winner_idx (winner_idx),
    .done       (done),
    .spurious   (spurious),
    .dup_err    (dup_err)
  );

endmodule

// File: rtl/sia_checker.sv
module sia_checker #(
  parameter int unsigned N     = 8,
  parameter int unsigned W     = 4,
  parameter int unsigned IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ack,
  input logic             done,
  input logic             spurious,
  input logic             dup_err,
  input logic [IDX_W-1:0] winner_idx,
  input logic             round_active,
  input logic [N-1:0]     contenders
);

  // Cycle count since the last accepted acknowledge, saturating.
  logic [7:0] since_start;
  logic       seen_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_start <= '0;
      seen_start  <= 1'b0;
    end else if (ack && !round_active) begin
      since_start <= '0;
      seen_start  <= 1'b1;
    end else if (since_start != 8'hFF) begin
      since_start <= since_start + 1'b1;
    end
  end

  p_done_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (seen_start && since_start == 8'(W)));

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_no_rejoin_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (round_active && $past(round_active)) |-> ((contenders & ~$past(contenders)) == '0));

  p_spur_idx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    spurious |-> (winner_idx == '0));

  p_spur_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(spurious && dup_err));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(winner_idx) && $stable(spurious) && $stable(dup_err)));

endmodule

bind serial_irq_arbiter sia_checker #(.N(N), .W(W), .IDX_W(IDX_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ack          (ack),
  .done         (done),
  .spurious     (spurious),
  .dup_err      (dup_err),
  .winner_idx   (winner_idx),
  .round_active (round_active),
  .contenders   (contenders)
);

// File: tb/serial_irq_arbiter_tb.sv
module serial_irq_arbiter_tb;

  localparam int N = 8;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] irq_req = '0;
  logic         ext_irq = 1'b0;
  logic [N-1:0] fld_load = '0;
  logic [W-1:0] fld_value = '0;
  logic         ack = 1'b0;
  logic [2:0]   winner_idx;
  logic         done;
  logic         spurious;
  logic         dup_err;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  logic [W-1:0] fmodel [N];

  always #2.5 clk = ~clk;

  serial_irq_arbiter #(.N(N), .W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .ext_irq(ext_irq),
    .fld_load(fld_load), .fld_value(fld_value), .ack(ack),
    .winner_idx(winner_idx), .done(done), .spurious(spurious), .dup_err(dup_err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Expected result by comparing numbers as integers: largest wins,
  // first index on ties.
  function automatic void model(input logic [N-1:0] r, output int win,
                                output bit spur, output bit dup);
    int best_v = 0;
    int best_i = 0;
    int cnt = 0;
    for (int i = 0; i < N; i++)
      if (r[i] && int'(fmodel[i]) > best_v) begin best_v = int'(fmodel[i]); best_i = i; end
    for (int i = 0; i < N; i++)
      if (r[i] && int'(fmodel[i]) == best_v) cnt++;
    spur = (best_v == 0);
    win  = spur ? 0 : best_i;
    dup  = !spur && cnt > 1;
  endfunction

  task automatic load_num(input int slot, input logic [W-1:0] v);
    @(negedge clk);
    fld_load = '0; fld_load[slot] = 1'b1; fld_value = v;
    fmodel[slot] = v;
    @(negedge clk);
    fld_load = '0;
  endtask

  task automatic run_round(input logic [N-1:0] r, input bit ext, input bit disturb, input string tag);
    int ew; bit es; bit ed;
    logic [N-1:0] eff;
    eff = r; eff[0] = eff[0] | ext;
    model(eff, ew, es, ed);
    @(negedge clk);
    irq_req = r; ext_irq = ext; ack = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      fld_load = '0;
      ack = 1'b0;
      chk(done == 1'b0, "R3 done early", int'(done), 0);
      if (disturb && k < 3) begin
        irq_req = N'($urandom);
        ext_irq = 1'($urandom);
        if (k == 1) ack = 1'b1;
        if (k < 2) begin
          automatic int s = $urandom_range(N - 1);
          fld_value = W'($urandom);
          fld_load[s] = 1'b1;
          fmodel[s] = fld_value;
        end
      end
    end
    @(negedge clk);
    chk(done == 1'b1, {tag, " R3/R5 done"}, int'(done), 1);
    chk(int'(winner_idx) == ew, {tag, " R4 winner"}, int'(winner_idx), ew);
    chk(spurious == es, {tag, " R6 spurious"}, int'(spurious), int'(es));
    chk(dup_err == ed, {tag, " R7 dup_err"}, int'(dup_err), int'(ed));
    irq_req = N'($urandom);
    @(negedge clk);
    chk(done == 1'b0, {tag, " R3 done one cycle"}, int'(done), 0);
    chk(int'(winner_idx) == ew && spurious == es && dup_err == ed,
        {tag, " R10 hold"}, int'(winner_idx), ew);
    irq_req = '0; ext_irq = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1357));
    for (int i = 0; i < N; i++) fmodel[i] = (i == 0) ? 4'hF : 4'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 0 && spurious == 0 && dup_err == 0 && winner_idx == 0,
        "reset outputs", int'({done, spurious, dup_err}), 0);

    // R1: reset numbers, slot 1 at zero is spurious, slot 0 at 1111 wins
    run_round(8'b0000_0010, 1'b0, 1'b0, "R1 slot1 zero");
    run_round(8'b0000_0011, 1'b0, 1'b0, "R1 slot0 ones");
    // R8: external request alone wins through slot 0
    run_round(8'b0000_0000, 1'b1, 1'b0, "R8 ext");
    // R5/R6: no request at all
    run_round(8'b0000_0000, 1'b0, 1'b0, "R6 none");
    // R2/R7: equal non-zero numbers tie, lowest index reported
    load_num(2, 4'h7);
    load_num(5, 4'h7);
    load_num(0, 4'h3);
    run_round(8'b0010_0101, 1'b0, 1'b0, "R2 R7 tie");
    // R4: bit-serial order matters (0110 beats 0101, 1000 beats 0111)
    load_num(3, 4'h6);
    load_num(4, 4'h5);
    run_round(8'b0001_1000, 1'b0, 1'b0, "R4 order");
    load_num(6, 4'h8);
    load_num(7, 4'h7);
    run_round(8'b1100_0000, 1'b0, 1'b0, "R4 msb");
    // R5: single requester still runs the full round
    run_round(8'b0100_0000, 1'b0, 1'b0, "R5 single");
    // R9: traffic during the round
    run_round(8'b1001_0100, 1'b0, 1'b1, "R9 disturb");

    for (int n = 0; n < 300; n++) begin
      if ($urandom_range(3) == 0)
        load_num($urandom_range(N - 1), ($urandom_range(4) == 0) ? 4'h0 : W'($urandom));
      run_round(N'($urandom), 1'($urandom_range(3) == 0), 1'($urandom_range(1)), "rand R4 R9");
    end
    finish_run();
  end

endmodule